// File: doc/BRIEF.md
# Register Rename Map with Pinned Zero Register

This block renames architectural registers for an out-of-order core. Each cycle one decoded instruction can present two logical source numbers, a logical destination and a write flag. The block returns the physical registers that hold the sources. When the instruction writes a register, it also takes a fresh physical register from a FIFO free pool and returns the mapping the destination held before, so that commit can hand that register back later. A small physical register file with one write port and one read port is included, so that register values can be written back and read out.

Logical register 0 has no special read path. After reset it points at physical register 0. That entry never enters the free pool and is never accepted back from commit. Instructions that name register 0 as their destination lose their write flag before renaming. Because the register file is cleared after reset, any read that reaches physical register 0 returns zero.

A two-state controller runs the block. In state ST_CLEAR it writes zero into one physical entry per cycle, starting at index 0. When it writes the last index it takes the transition CLEAR_DONE into state ST_RUN. It stays in ST_RUN until reset, and reset takes it back to ST_CLEAR from either state.

Top module: `rnm_top`

## Requirements
- R1: After reset is released, `ready` stays low for exactly NUM_PHYS cycles (one zero write per physical entry, indices 0 upward) and then goes high. From then on every physical entry reads as 0 until it is written back.
- R2: A rename whose destination is logical 0 drops its write flag. `ren_eff_we` is 0 and `ren_pdst` is 0. No free register is taken, it never stalls even when the pool is empty, and the mapping table is left unchanged.
- R3: Logical register 0 maps to physical 0 at all times. A source lookup of logical 0 returns physical 0, and reading physical 0 returns 0.
- R4: After reset, logical register i (for 1 ≤ i < NUM_LOG) maps to physical register i.
- R5: The free pool starts with physical registers NUM_LOG to NUM_PHYS-1. Allocation follows FIFO order: the lowest index goes first, and released registers join the tail.
- R6: On an accepted rename with an effective write, `ren_pold` gives the mapping the destination held before, and later lookups of that destination return the new `ren_pdst`.
- R7: Source lookups in a rename see the mapping from before that same instruction updates its destination.
- R8: When the pool is empty, a rename with an effective write raises `ren_stall`. Nothing is allocated and the mapping stays unchanged.
- R9: A release (`rel_valid`) of physical register 0 is ignored. A release of any other register appends it to the free pool.
- R10: While `ready` is low, every valid rename is stalled.
- R11: A writeback to physical register p with data d makes `rd_data` return d when `rd_preg` is p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ready | output | 1 | High once the register file clear has finished |
| ren_valid | input | 1 | Rename request present |
| ren_we | input | 1 | Instruction writes its destination, as decoded |
| ren_dst | input | LW | Logical destination |
| ren_src_a | input | LW | Logical source A |
| ren_src_b | input | LW | Logical source B |
| ren_stall | output | 1 | Request not accepted this cycle |
| ren_eff_we | output | 1 | Write flag after zero-destination suppression |
| ren_psrc_a | output | PW | Physical register for source A |
| ren_psrc_b | output | PW | Physical register for source B |
| ren_pdst | output | PW | Newly allocated physical destination, 0 when there is no write |
| ren_pold | output | PW | Previous mapping of the destination |
| rel_valid | input | 1 | Commit releases a physical register |
| rel_preg | input | PW | Register being released |
| wb_valid | input | 1 | Writeback into the register file |
| wb_preg | input | PW | Writeback index |
| wb_data | input | DATA_W | Writeback data |
| rd_preg | input | PW | Read index |
| rd_data | output | DATA_W | Read data, combinational |

## Verification
The bench targets the cases where the zero register would leak into the rename flow. If a destination-0 write were not suppressed, the next real allocation would come out one register later than expected. If register 0 were accepted on release, a stalled rename would resume and hand out physical 0. A missing reset clear would show non-zero data on the register file read sweep, and a wrong clear counter would make `ready` rise too early or too late. The bench also drains the free pool completely to check that a stalled rename leaves its destination mapping unchanged, and it reads sources in the same instruction that redefines them, where a design that applied the update first would return the new register.

// File: rtl/rnm_pkg.sv
package rnm_pkg;
    typedef enum logic [0:0] {
        ST_CLEAR = 1'b0,
        ST_RUN   = 1'b1
    } rnm_state_e;
endpackage

// File: rtl/rnm_prf.sv
module rnm_prf #(
    parameter int NUM_PHYS = 16,
    parameter int DATA_W   = 32,
    localparam int PW      = $clog2(NUM_PHYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PW-1:0]     wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PW-1:0]     rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem_q [NUM_PHYS];

    // storage has no reset of its own; the controller clears it
    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_idx] <= wr_data;
    end

    assign rd_data = mem_q[rd_idx];

    // R3
    prf_zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == '0) |-> (wr_data == '0));
endmodule

// File: rtl/rnm_freelist.sv
module rnm_freelist #(
    parameter int NUM_LOG  = 8,
    parameter int NUM_PHYS = 16,
    localparam int PW      = $clog2(NUM_PHYS),
    localparam int CW      = $clog2(NUM_PHYS + 1),
    localparam int INIT_CNT = NUM_PHYS - NUM_LOG,
    localparam int CAP      = NUM_PHYS - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop,
    input  logic          push,
    input  logic [PW-1:0] push_idx,
    output logic [PW-1:0] head_idx,
    output logic          empty
);
    logic [PW-1:0] slot_q [NUM_PHYS];
    logic [PW-1:0] rd_ptr_q, wr_ptr_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PHYS; i++) begin
                slot_q[i] <= (i < INIT_CNT) ? PW'(NUM_LOG + i) : '0;
            end
            rd_ptr_q <= '0;
            wr_ptr_q <= PW'(INIT_CNT);
            cnt_q    <= CW'(INIT_CNT);
        end else begin
            if (push) begin
                slot_q[wr_ptr_q] <= push_idx;
                wr_ptr_q         <= wr_ptr_q + 1'b1;
            end
            if (pop) rd_ptr_q <= rd_ptr_q + 1'b1;
            unique case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign head_idx = slot_q[rd_ptr_q];
    assign empty    = (cnt_q == '0);

    // R8
    fl_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    // R9
    fl_zero_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (push_idx != '0));
    // R5
    fl_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (cnt_q < CW'(CAP)));
endmodule

// File: rtl/rnm_maptable.sv
module rnm_maptable #(
    parameter int NUM_LOG  = 8,
    parameter int NUM_PHYS = 16,
    localparam int LW      = $clog2(NUM_LOG),
    localparam int PW      = $clog2(NUM_PHYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] rd_a_idx,
    input  logic [LW-1:0] rd_b_idx,
    input  logic [LW-1:0] rd_d_idx,
    output logic [PW-1:0] rd_a_preg,
    output logic [PW-1:0] rd_b_preg,
    output logic [PW-1:0] rd_d_preg,
    input  logic          wr_en,
    input  logic [LW-1:0] wr_idx,
    input  logic [PW-1:0] wr_preg
);
    logic [PW-1:0] map_q [NUM_LOG];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LOG; i++) map_q[i] <= PW'(i);
        end else if (wr_en) begin
            map_q[wr_idx] <= wr_preg;
        end
    end

    // lookups read the registered table, i.e. the state before this cycle's update
    assign rd_a_preg = map_q[rd_a_idx];
    assign rd_b_preg = map_q[rd_b_idx];
    assign rd_d_preg = map_q[rd_d_idx];

    // R3
    map_zero_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        map_q[0] == '0);
endmodule

// File: rtl/rnm_top.sv
module rnm_top
    import rnm_pkg::*;
#(
    parameter int NUM_LOG  = 8,
    parameter int NUM_PHYS = 16,
    parameter int DATA_W   = 32,
    localparam int LW      = $clog2(NUM_LOG),
    localparam int PW      = $clog2(NUM_PHYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              ready,
    input  logic              ren_valid,
    input  logic              ren_we,
    input  logic [LW-1:0]     ren_dst,
    input  logic [LW-1:0]     ren_src_a,
    input  logic [LW-1:0]     ren_src_b,
    output logic              ren_stall,
    output logic              ren_eff_we,
    output logic [PW-1:0]     ren_psrc_a,
    output logic [PW-1:0]     ren_psrc_b,
    output logic [PW-1:0]     ren_pdst,
    output logic [PW-1:0]     ren_pold,
    input  logic              rel_valid,
    input  logic [PW-1:0]     rel_preg,
    input  logic              wb_valid,
    input  logic [PW-1:0]     wb_preg,
    input  logic [DATA_W-1:0] wb_data,
    input  logic [PW-1:0]     rd_preg,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [PW-1:0] LAST_IDX = PW'(NUM_PHYS - 1);

    rnm_state_e    state_q, state_d;
    logic [PW-1:0] clr_cnt_q;
    logic          clearing;

    // state register and clear counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_CLEAR;
            clr_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            if (clearing) clr_cnt_q <= clr_cnt_q + 1'b1;
        end
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        clearing = 1'b0;
        ready    = 1'b0;
        unique case (state_q)
            ST_CLEAR: begin
                clearing = 1'b1;
                if (clr_cnt_q == LAST_IDX) state_d = ST_RUN;
            end
            ST_RUN: begin
                ready = 1'b1;
            end
            default: state_d = ST_CLEAR;
        endcase
    end

    // decode-side suppression of writes to logical 0
    logic fl_empty, alloc, accept, rel_push;
    logic [PW-1:0] fl_head, map_dst_preg;

    assign ren_eff_we = ren_we && (ren_dst != '0);
    assign ren_stall  = ren_valid && (!ready || (ren_eff_we && fl_empty));
    assign accept     = ren_valid && !ren_stall;
    assign alloc      = accept && ren_eff_we;
    assign ren_pdst   = ren_eff_we ? fl_head : '0;
    assign ren_pold   = map_dst_preg;
    assign rel_push   = rel_valid && ready && (rel_preg != '0);

    rnm_maptable #(.NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_idx  (ren_src_a),
        .rd_b_idx  (ren_src_b),
        .rd_d_idx  (ren_dst),
        .rd_a_preg (ren_psrc_a),
        .rd_b_preg (ren_psrc_b),
        .rd_d_preg (map_dst_preg),
        .wr_en     (alloc),
        .wr_idx    (ren_dst),
        .wr_preg   (fl_head)
    );

    rnm_freelist #(.NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS)) u_free (
        .clk      (clk),
        .rst_n    (rst_n),
        .pop      (alloc),
        .push     (rel_push),
        .push_idx (rel_preg),
        .head_idx (fl_head),
        .empty    (fl_empty)
    );

    logic              prf_we;
    logic [PW-1:0]     prf_idx;
    logic [DATA_W-1:0] prf_wdata;

    assign prf_we    = clearing || (wb_valid && ready);
    assign prf_idx   = clearing ? clr_cnt_q : wb_preg;
    assign prf_wdata = clearing ? '0 : wb_data;

    rnm_prf #(.NUM_PHYS(NUM_PHYS), .DATA_W(DATA_W)) u_prf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (prf_we),
        .wr_idx  (prf_idx),
        .wr_data (prf_wdata),
        .rd_idx  (rd_preg),
        .rd_data (rd_data)
    );

    // R1
    clr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> ($past(clr_cnt_q) == LAST_IDX));
    // R5
    alloc_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> (fl_head != '0));
    // R2
    zero_dst_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && ren_dst == '0) |=> (u_map.map_q[0] == '0));
endmodule

// File: tb/rnm_top_tb.sv
module rnm_top_tb;
    localparam int NUM_LOG  = 8;
    localparam int NUM_PHYS = 16;
    localparam int DATA_W   = 32;
    localparam int LW       = $clog2(NUM_LOG);
    localparam int PW       = $clog2(NUM_PHYS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ready;
    logic ren_valid = 1'b0, ren_we = 1'b0;
    logic [LW-1:0] ren_dst = '0, ren_src_a = '0, ren_src_b = '0;
    logic ren_stall, ren_eff_we;
    logic [PW-1:0] ren_psrc_a, ren_psrc_b, ren_pdst, ren_pold;
    logic rel_valid = 1'b0;
    logic [PW-1:0] rel_preg = '0;
    logic wb_valid = 1'b0;
    logic [PW-1:0] wb_preg = '0;
    logic [DATA_W-1:0] wb_data = '0;
    logic [PW-1:0] rd_preg = '0;
    logic [DATA_W-1:0] rd_data;

    always #2 clk = ~clk;

    rnm_top #(.NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .ready(ready),
        .ren_valid(ren_valid), .ren_we(ren_we), .ren_dst(ren_dst),
        .ren_src_a(ren_src_a), .ren_src_b(ren_src_b),
        .ren_stall(ren_stall), .ren_eff_we(ren_eff_we),
        .ren_psrc_a(ren_psrc_a), .ren_psrc_b(ren_psrc_b),
        .ren_pdst(ren_pdst), .ren_pold(ren_pold),
        .rel_valid(rel_valid), .rel_preg(rel_preg),
        .wb_valid(wb_valid), .wb_preg(wb_preg), .wb_data(wb_data),
        .rd_preg(rd_preg), .rd_data(rd_data)
    );

    typedef struct {
        int    psa;
        int    psb;
        int    pd;
        int    po;
        bit    eff;
        bit    stall;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   bmap[NUM_LOG];
    int   bfree[$];
    bit   drv_valid = 1'b0;
    bit   done = 1'b0;
    int   checks = 0;
    int   errors = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic quiet();
        @(posedge clk); #1;
        ren_valid = 1'b0; drv_valid = 1'b0;
        rel_valid = 1'b0; wb_valid = 1'b0;
    endtask

    // driver: computes the expected result from the model and queues it
    task automatic rename(input int dst, input bit we, input int sa, input int sb, input string tag);
        exp_t e;
        @(posedge clk); #1;
        rel_valid = 1'b0; wb_valid = 1'b0;
        ren_valid = 1'b1; ren_we = we;
        ren_dst = LW'(dst); ren_src_a = LW'(sa); ren_src_b = LW'(sb);
        e.psa = bmap[sa]; e.psb = bmap[sb];
        e.eff = we && (dst != 0);
        e.stall = e.eff && (bfree.size() == 0);
        e.po = bmap[dst];
        e.pd = 0;
        e.tag = tag;
        if (e.eff && !e.stall) begin
            e.pd = bfree.pop_front();
            bmap[dst] = e.pd;
        end
        exp_q.push_back(e);
        drv_valid = 1'b1;
    endtask

    task automatic release_reg(input int p);
        @(posedge clk); #1;
        ren_valid = 1'b0; drv_valid = 1'b0; wb_valid = 1'b0;
        rel_valid = 1'b1; rel_preg = PW'(p);
        if (p != 0) bfree.push_back(p);
    endtask

    task automatic writeback(input int p, input logic [DATA_W-1:0] d);
        @(posedge clk); #1;
        ren_valid = 1'b0; drv_valid = 1'b0; rel_valid = 1'b0;
        wb_valid = 1'b1; wb_preg = PW'(p); wb_data = d;
    endtask

    task automatic read_check(input int p, input logic [DATA_W-1:0] d, input string tag);
        quiet();
        rd_preg = PW'(p);
        #1;
        chk(rd_data == d, tag, int'(rd_data), int'(d));
    endtask

    // monitor: pops the queue and compares at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (drv_valid) begin
                exp_t e;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "scoreboard underrun", 0, 1);
                end else begin
                    e = exp_q.pop_front();
                    chk(ren_stall == e.stall, {e.tag, " stall"}, int'(ren_stall), int'(e.stall));
                    chk(ren_eff_we == e.eff, {e.tag, " eff_we"}, int'(ren_eff_we), int'(e.eff));
                    chk(int'(ren_psrc_a) == e.psa, {e.tag, " psrc_a"}, int'(ren_psrc_a), e.psa);
                    chk(int'(ren_psrc_b) == e.psb, {e.tag, " psrc_b"}, int'(ren_psrc_b), e.psb);
                    if (!e.stall) begin
                        chk(int'(ren_pdst) == e.pd, {e.tag, " pdst"}, int'(ren_pdst), e.pd);
                        if (e.eff)
                            chk(int'(ren_pold) == e.po, {e.tag, " pold"}, int'(ren_pold), e.po);
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int cyc;
        for (int i = 0; i < NUM_LOG; i++) bmap[i] = i;
        for (int p = NUM_LOG; p < NUM_PHYS; p++) bfree.push_back(p);

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R10: requests stall during the clear phase
        ren_valid = 1'b1; ren_we = 1'b1; ren_dst = LW'(1);
        #1;
        chk(ready == 1'b0, "R1 ready low after reset", int'(ready), 0);
        chk(ren_stall == 1'b1, "R10 stall while clearing", int'(ren_stall), 1);
        ren_valid = 1'b0;
        cyc = 0;
        while (!ready && cyc < 100) begin
            @(posedge clk); #1;
            cyc++;
        end
        chk(cyc == NUM_PHYS, "R1 clear length", cyc, NUM_PHYS);
        for (int p = 0; p < NUM_PHYS; p++) begin
            rd_preg = PW'(p);
            #1;
            chk(rd_data == '0, "R1 entry cleared", int'(rd_data), 0);
        end

        // R4, R3: identity mapping, logical 0 on physical 0
        for (int i = 0; i < NUM_LOG; i++) rename(i, 1'b0, i, (i + 1) % NUM_LOG, "R4 identity");
        read_check(0, '0, "R3 zero reads zero");

        // R2: destination 0 takes nothing from the pool
        rename(0, 1'b1, 0, 2, "R2 zero dst");
        // R7 and R6: source reads old mapping, pold returned; R5 FIFO head
        rename(3, 1'b1, 3, 0, "R7 R6 R5 first alloc");
        rename(4, 1'b0, 3, 0, "R6 new mapping visible");
        // drain the pool
        rename(1, 1'b1, 1, 2, "R5 drain");
        rename(2, 1'b1, 2, 3, "R5 drain");
        rename(4, 1'b1, 4, 5, "R5 drain");
        rename(5, 1'b1, 5, 6, "R5 drain");
        rename(6, 1'b1, 6, 7, "R5 drain");
        rename(7, 1'b1, 7, 1, "R5 drain");
        rename(1, 1'b1, 1, 2, "R5 drain last");
        rename(2, 1'b1, 2, 0, "R8 stall on empty");
        rename(0, 1'b0, 2, 1, "R8 map unchanged");
        rename(0, 1'b1, 0, 2, "R2 zero dst no stall when empty");
        // R9: release of physical 0 ignored
        release_reg(0);
        rename(2, 1'b1, 2, 0, "R9 zero release ignored");
        release_reg(3);
        rename(2, 1'b1, 2, 0, "R9 released reg reused");
        rename(0, 1'b0, 2, 0, "R9 mapping after reuse");
        // R11: writeback and read
        writeback(3, 32'hA5A5_1234);
        read_check(3, 32'hA5A5_1234, "R11 writeback readout");
        writeback(9, 32'h0000_00FF);
        read_check(9, 32'h0000_00FF, "R11 second writeback");
        rename(0, 1'b0, 0, 0, "R3 logical 0 lookup late");
        read_check(0, '0, "R3 zero still zero");
        quiet();
        repeat (2) @(posedge clk);
        chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule